// File: doc/BRIEF.md
# UART Interrupt Request Priority Controller

This block holds the interrupt control state for the transmit and receive events of a set of UART channels. Each source owns one small control register: a 3-bit priority level and a pending-request flag. Transmit flags are raised when a byte is loaded from the transmit holding register into the shift register. Receive flags are raised when a received byte is moved into the receive holding register, unless that move reports an overrun. Software reads and writes the registers over a simple byte-wide register bus and can set or clear any flag.

The block filters the pending requests against the processor's current priority level and its global interrupt-disable flag. It then picks one winner and presents it to the CPU as a registered valid, source index and level. When the CPU pulses accept, the flag of the presented source is cleared.

Top module: `uart_irq_prio`

## Requirements
- R1: On synchronous active-high reset, every level field and request flag becomes 0, `irq_valid`, `irq_index` and `irq_level` become 0, and `bus_rdata` becomes 0.
- R2: The registers sit at BASE_ADDR+0..+3 (default 0x71..0x74) in the order channel 0 transmit, channel 0 receive, channel 1 transmit, channel 1 receive. A write stores data bit 3 as the request flag and bits 2:0 as the level. `bus_rdata` returns {0000, flag, level} of the addressed register one clock later. Other addresses read as 0 and writes to them change nothing.
- R3: A `tx_load[c]` pulse sets the request flag of source 2c.
- R4: A `rx_load[c]` pulse sets the request flag of source 2c+1, except when `rx_overrun[c]` is high in the same cycle; the flag then keeps its value.
- R5: An `irq_ack` pulse while `irq_valid` is high clears only the flag of the source shown on `irq_index`. While `irq_valid` is low it has no effect.
- R6: In one cycle, a hardware set wins over a bus write to the same flag, and a bus write wins over an accept clear.
- R7: A source is eligible only when its flag is 1, its level is strictly greater than `cpu_ipl`, and `cpu_idis` is 0. Level 0 is therefore never eligible.
- R8: Among the eligible sources, the one with the highest level is presented. A tie goes to the lowest index.
- R9: `irq_valid`, `irq_index` and `irq_level` are registered. At each edge they take the winner computed from the register contents written at that edge and the `cpu_ipl` and `cpu_idis` values sampled at that edge. With no eligible source, all three are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address for both reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tx_load | input | 2 | Per channel: transmit byte moved into the shift register |
| rx_load | input | 2 | Per channel: received byte moved into the holding register |
| rx_overrun | input | 2 | Per channel: the receive move came with an overrun |
| cpu_ipl | input | 3 | Processor interrupt priority level |
| cpu_idis | input | 1 | Global interrupt disable |
| irq_ack | input | 1 | CPU accepts the presented request |
| irq_valid | output | 1 | A request is presented |
| irq_index | output | 2 | Index of the presented source |
| irq_level | output | 3 | Level of the presented source |

## Verification
The bench drives a receive load together with an overrun. A design that ignored the overrun would raise a spurious receive request. It also hits a flag with a hardware set, a bus write and an accept in the same cycle; a wrong precedence order would leave the flag in the wrong state. It sets the processor level equal to a source's level, which catches a design that compares with greater-or-equal. It gives two sources equal levels, where a design with the wrong tie order would present the higher index. It also checks that an accept given while nothing is presented clears nothing. Long random runs then cover interleaved events, writes and accepts against the reference model.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  // selects which member of a source pair inside one channel
  typedef enum logic {
    SRC_TX = 1'b0,
    SRC_RX = 1'b1
  } src_kind_e;
endpackage

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg #(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hw_set,
  input  logic             sw_wr,
  input  logic [LVL_W:0]   sw_data,
  input  logic             ack_clr,
  output logic             flag_q,
  output logic [LVL_W-1:0] lvl_q,
  output logic             flag_d,
  output logic [LVL_W-1:0] lvl_d
);
  // precedence: hardware set, then bus write, then accept clear
  always_comb begin
    if (hw_set)       flag_d = 1'b1;
    else if (sw_wr)   flag_d = sw_data[LVL_W];
    else if (ack_clr) flag_d = 1'b0;
    else              flag_d = flag_q;
    lvl_d = sw_wr ? sw_data[LVL_W-1:0] : lvl_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      lvl_q  <= '0;
    end else begin
      flag_q <= flag_d;
      lvl_q  <= lvl_d;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NSRC  = 4,
  parameter int LVL_W = 3,
  parameter int IDX_W = 2
) (
  input  logic [NSRC-1:0]       flags,
  input  logic [NSRC*LVL_W-1:0] levels,
  input  logic [LVL_W-1:0]      ipl,
  input  logic                  idis,
  output logic                  win_valid,
  output logic [IDX_W-1:0]      win_idx,
  output logic [LVL_W-1:0]      win_lvl
);
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_lvl   = '0;
    for (int i = 0; i < NSRC; i++) begin
      // strict compare keeps the lower index on a tie
      if (flags[i] && !idis && (levels[i*LVL_W +: LVL_W] > ipl) &&
          (!win_valid || (levels[i*LVL_W +: LVL_W] > win_lvl))) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        win_lvl   = levels[i*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio #(
  parameter int             NUM_CH    = 2,
  parameter int             LVL_W     = 3,
  parameter int             ADDR_W    = 8,
  parameter int             DATA_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h71
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bus_wr,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata,
  input  logic [NUM_CH-1:0]           tx_load,
  input  logic [NUM_CH-1:0]           rx_load,
  input  logic [NUM_CH-1:0]           rx_overrun,
  input  logic [LVL_W-1:0]            cpu_ipl,
  input  logic                        cpu_idis,
  input  logic                        irq_ack,
  output logic                        irq_valid,
  output logic [$clog2(2*NUM_CH)-1:0] irq_index,
  output logic [LVL_W-1:0]            irq_level
);
  import uart_irq_pkg::*;

  localparam int NSRC  = 2 * NUM_CH;
  localparam int IDX_W = $clog2(NSRC);
  localparam int PAD_W = DATA_W - LVL_W - 1;

  logic [NSRC-1:0]       src_set, src_wr, src_ack, flag_q, flag_d;
  logic [NSRC*LVL_W-1:0] lvl_q, lvl_d;
  logic                  win_valid;
  logic [IDX_W-1:0]      win_idx;
  logic [LVL_W-1:0]      win_lvl;

  // event mapping: even index transmit, odd index receive
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign src_set[2*c + int'(SRC_TX)] = tx_load[c];
    assign src_set[2*c + int'(SRC_RX)] = rx_load[c] & ~rx_overrun[c];
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign src_wr[i]  = bus_wr && (bus_addr == BASE_ADDR + ADDR_W'(i));
    assign src_ack[i] = irq_ack && irq_valid && (irq_index == IDX_W'(i));

    irq_ctl_reg #(.LVL_W(LVL_W)) u_reg (
      .clk     (clk),
      .rst     (rst),
      .hw_set  (src_set[i]),
      .sw_wr   (src_wr[i]),
      .sw_data (bus_wdata[LVL_W:0]),
      .ack_clr (src_ack[i]),
      .flag_q  (flag_q[i]),
      .lvl_q   (lvl_q[i*LVL_W +: LVL_W]),
      .flag_d  (flag_d[i]),
      .lvl_d   (lvl_d[i*LVL_W +: LVL_W])
    );
  end

  // arbitrate on the values being written so outputs track in one edge
  irq_arbiter #(.NSRC(NSRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_arb (
    .flags     (flag_d),
    .levels    (lvl_d),
    .ipl       (cpu_ipl),
    .idis      (cpu_idis),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_lvl   (win_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid <= 1'b0;
      irq_index <= '0;
      irq_level <= '0;
    end else begin
      irq_valid <= win_valid;
      irq_index <= win_idx;
      irq_level <= win_lvl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
      for (int i = 0; i < NSRC; i++) begin
        if (bus_addr == BASE_ADDR + ADDR_W'(i))
          bus_rdata <= {{PAD_W{1'b0}}, flag_q[i], lvl_q[i*LVL_W +: LVL_W]};
      end
    end
  end
endmodule

// File: rtl/uart_irq_prio_chk.sv
module uart_irq_prio_chk #(
  parameter int LVL_W  = 3,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [LVL_W-1:0]  cpu_ipl,
  input logic              cpu_idis,
  input logic              irq_valid,
  input logic [IDX_W-1:0]  irq_index,
  input logic [LVL_W-1:0]  irq_level,
  input logic [DATA_W-1:0] bus_rdata
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!irq_valid && irq_level == '0 && bus_rdata == '0));

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_valid |-> (irq_index == '0 && irq_level == '0));

  // R7
  above_ipl_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_valid) |-> (irq_level > $past(cpu_ipl) && !$past(cpu_idis)));

  // R7
  nonzero_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> irq_level != '0);

  // R2
  pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DATA_W-1:LVL_W+1] == '0);
endmodule

bind uart_irq_prio uart_irq_prio_chk #(
  .LVL_W(LVL_W), .IDX_W(IDX_W), .DATA_W(DATA_W)
) chk_i (
  .clk(clk), .rst(rst), .cpu_ipl(cpu_ipl), .cpu_idis(cpu_idis),
  .irq_valid(irq_valid), .irq_index(irq_index), .irq_level(irq_level),
  .bus_rdata(bus_rdata)
);

// File: tb/uart_irq_prio_test.sv
`timescale 1ns/1ps
module uart_irq_prio_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [1:0] tx_load = '0, rx_load = '0, rx_overrun = '0;
  logic [2:0] cpu_ipl = '0;
  logic       cpu_idis = 1'b0, irq_ack = 1'b0;
  logic       irq_valid;
  logic [1:0] irq_index;
  logic [2:0] irq_level;

  int checks = 0, errors = 0;
  int m_lvl[4], m_flg[4];
  int e_valid = 0, e_idx = 0, e_lvl = 0, e_rd = 0;

  always #5 clk = ~clk;

  uart_irq_prio uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_load(tx_load),
    .rx_load(rx_load), .rx_overrun(rx_overrun), .cpu_ipl(cpu_ipl),
    .cpu_idis(cpu_idis), .irq_ack(irq_ack), .irq_valid(irq_valid),
    .irq_index(irq_index), .irq_level(irq_level)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    bus_wr = 0; tx_load = '0; rx_load = '0; rx_overrun = '0; irq_ack = 0;
  endtask

  // one clock: update reference model at the edge, compare mid-cycle
  task automatic step(string tag);
    int nf[4], nl[4], best;
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < 4; i++) begin m_flg[i] = 0; m_lvl[i] = 0; end
      e_valid = 0; e_idx = 0; e_lvl = 0; e_rd = 0;
    end else begin
      e_rd = 0;
      for (int i = 0; i < 4; i++) begin
        bit set, wr, ack;
        if (int'(bus_addr) == 'h71 + i) e_rd = m_flg[i] * 8 + m_lvl[i];
        set = (i % 2 == 0) ? tx_load[i/2] : (rx_load[i/2] && !rx_overrun[i/2]);
        wr  = bus_wr && (int'(bus_addr) == 'h71 + i);
        ack = irq_ack && (e_valid != 0) && (e_idx == i);
        nf[i] = set ? 1 : wr ? int'(bus_wdata[3]) : ack ? 0 : m_flg[i];
        nl[i] = wr ? int'(bus_wdata[2:0]) : m_lvl[i];
      end
      best = -1;
      for (int i = 0; i < 4; i++)
        if (nf[i] == 1 && nl[i] > int'(cpu_ipl) && !cpu_idis &&
            (best < 0 || nl[i] > nl[best])) best = i;
      for (int i = 0; i < 4; i++) begin m_flg[i] = nf[i]; m_lvl[i] = nl[i]; end
      e_valid = (best >= 0); e_idx = (best >= 0) ? best : 0;
      e_lvl = (best >= 0) ? nl[best] : 0;
    end
    @(negedge clk);
    check({tag, " irq_valid"}, int'(irq_valid), e_valid);
    check({tag, " irq_index"}, int'(irq_index), e_idx);
    check({tag, " irq_level"}, int'(irq_level), e_lvl);
    check({tag, " bus_rdata"}, int'(bus_rdata), e_rd);
  endtask

  task automatic wr(int a, int d, string tag);
    bus_wr = 1; bus_addr = 8'(a); bus_wdata = 8'(d);
    step(tag); idle();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    rst = 1; step("R1 reset"); step("R1 reset");
    rst = 0; step("R1 after reset");
    // R2: register map, read back, out-of-range address
    wr('h72, 'h0d, "R2 write rx0");
    bus_addr = 8'h72; step("R2 readback");
    wr('h75, 'hff, "R2 stray write");
    bus_addr = 8'h75; step("R2 stray read");
    wr('h72, 'h00, "R2 clear rx0");
    // R3: transmit load on channel 1 with level 4
    wr('h73, 'h04, "R3 set level");
    tx_load = 2'b10; step("R3 tx load"); idle();
    // R5: accept clears presented source
    irq_ack = 1; step("R5 accept"); idle();
    irq_ack = 1; step("R5 accept idle"); idle();
    bus_addr = 8'h73; step("R5 readback");
    // R4: receive load with overrun is ignored
    wr('h72, 'h06, "R4 set level");
    rx_load = 2'b01; rx_overrun = 2'b01; step("R4 overrun load"); idle();
    bus_addr = 8'h72; step("R4 readback");
    rx_load = 2'b01; step("R4 clean load"); idle();
    // R6: hardware set beats a clearing write
    tx_load = 2'b01; bus_wr = 1; bus_addr = 8'h71; bus_wdata = 8'h05;
    step("R6 set vs write"); idle();
    bus_addr = 8'h71; step("R6 readback");
    // R6: write beats accept clear on presented rx0
    irq_ack = 1; bus_wr = 1; bus_addr = 8'h72; bus_wdata = 8'h0e;
    step("R6 write vs accept"); idle();
    // R7: equal level is not above ipl; disable flag blocks
    cpu_ipl = 3'd6; step("R7 ipl equal");
    cpu_ipl = 3'd0; cpu_idis = 1; step("R7 idis");
    cpu_idis = 0; wr('h74, 'h08, "R7 level zero");
    // R8: tie between rx0 and tx0
    wr('h71, 'h0e, "R8 tie"); step("R8 tie hold");
    // random mix, R2 through R9
    for (int n = 0; n < 4000; n++) begin
      bus_wr     = ($urandom % 6) == 0;
      bus_addr   = 8'('h70 + $urandom % 6);
      bus_wdata  = 8'($urandom);
      tx_load    = 2'($urandom % 4 & {1'b1, ($urandom % 3) == 0});
      rx_load    = 2'($urandom % 4);
      rx_overrun = 2'($urandom % 4);
      irq_ack    = ($urandom % 3) == 0;
      cpu_ipl    = 3'($urandom % 8);
      cpu_idis   = ($urandom % 10) == 0;
      step("R9 random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule